// File: doc/BRIEF.md
# USB Device Endpoint Enable and Reset Control

This block holds the per-endpoint enable and reset controls for a USB device function with ten endpoints. Software sets them through one 32-bit control word on a simple register port. From this word the block decides, for each endpoint, three things. It decides whether the endpoint answers the bus, whether its FIFO and transfer state are held in reset, and whether its option, status and mask registers are held clear. The packet engine and FIFO memory are outside the block. Each endpoint's FIFO is modelled by a byte counter that is filled over a valid/ready push handshake. Its transfer status is modelled by sticky flags.

Disabling an endpoint and resetting it clear different sets of state. A disabled endpoint drops off the bus and loses its counter, option bits, status and mask. The endpoint reset clears the same state, but the endpoint stays on the bus. Neither touches the kept configuration fields: allocation, bank count, size, direction and type. Neither touches the data-toggle value either. Only a dedicated per-endpoint toggle-clear request resets the toggle. A USB bus reset drops every endpoint reset bit and leaves the enables alone.

Push back-pressure is set by the endpoint alone. `push_ready` for an endpoint is high only when it is enabled, out of reset and its counter is below full. A byte is counted only on a cycle where valid and ready are both high. `push_valid` may be held or dropped at any time.

Top module: `usb_ep_gate`

## Requirements
- R1: The control word sits at address 0x1C. Bit i (i = 0..9) is the enable of endpoint i, and bit 16+i is the reset of endpoint i. All other bits read as 0. Writes to any other address change nothing, and reads of any other address return 0.
- R2: After hardware reset, all enable and reset bits are 0. All counters, toggles, configuration, status and mask values are also 0.
- R3: A read returns the control word on `reg_rdata` in the cycle after the read strobe. That value is the word as it stood before any write in the same cycle. `reg_rdata` is 0 in the cycle after a cycle with no read.
- R4: `ep_active[i]` equals enable bit i, and `ep_reset[i]` equals reset bit i.
- R5: While endpoint i is disabled, these values are cleared from the next edge on: its counter, its option bits (`cfg_wdata[10:9]`), its status flags and its mask. Its kept configuration fields (`cfg_wdata[8:0]`) hold, and writes to those fields are still accepted.
- R6: While reset bit i is 1, endpoint i is cleared like a disabled one. Its `ep_active` stays 1, and its kept configuration and toggle value hold.
- R7: Writing reset bit i back to 0 lets endpoint i count pushes again from the next cycle.
- R8: `bus_reset` clears every reset bit at the next edge and leaves the enable bits unchanged. It wins over a control-word write in the same cycle.
- R9: The 2-bit toggle of endpoint i clears only on `tog_clr[i]`. It advances by one, modulo 4, on `tog_adv[i]` when the endpoint is enabled and not in reset, and `tog_clr` wins. Disable and endpoint reset leave it unchanged.
- R10: `push_ready[i]` is high exactly when endpoint i is enabled, out of reset and its counter is below 2047. The counter increments on valid and ready together and stops at 2047.
- R11: A `tog_clr[i]` arriving in the same cycle as a write that sets reset bit i has both effects: the toggle clears and the reset bit sets.
- R12: A control-word write takes effect at the clock edge that samples `reg_wr`. The new enable and reset values are visible in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset, synchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after `reg_rd` |
| bus_reset | input | 1 | USB bus reset seen on the line |
| tog_clr | input | 10 | Per-endpoint data-toggle clear request |
| tog_adv | input | 10 | Per-endpoint toggle advance from the packet engine |
| push_valid | input | 10 | Per-endpoint FIFO byte push, valid |
| push_ready | output | 10 | Per-endpoint FIFO byte push, ready |
| cfg_wr | input | 10 | Per-endpoint configuration write strobe |
| cfg_wdata | input | 11 | Shared configuration data: [8:0] kept fields, [10:9] option bits |
| mask_wr | input | 10 | Per-endpoint mask write strobe |
| mask_wdata | input | 4 | Shared mask write data |
| stat_set | input | 10 | Per-endpoint status set strobe |
| stat_bits | input | 4 | Status flags to OR in |
| ep_active | output | 10 | Endpoint answers the bus |
| ep_reset | output | 10 | Endpoint FIFO and transfer state held in reset |
| ep_cnt | output | 110 | Byte counters, 11 bits per endpoint, endpoint 0 in the low bits |
| ep_tog | output | 20 | Data-toggle values, 2 bits per endpoint |
| ep_cfg | output | 110 | Configuration, 11 bits per endpoint |
| ep_stat | output | 40 | Status flags, 4 bits per endpoint |
| ep_mask | output | 40 | Mask, 4 bits per endpoint |

## Verification
The clearing rules are tried with several stimulus patterns. In random traffic, dense pushes, status sets and toggle advances land while sparse control writes flip enables and reset bits. This separates what disable clears, what endpoint reset clears and what both leave alone. A steady push stream into one endpoint walks its counter to full, which separates saturation from wrap-around. Directed cases line up collisions on single edges: a toggle clear with a reset-bit write, and a bus reset with a write that sets reset bits. These cases show which event wins. A read issued together with a write shows whether the read returns the old word or the new one.

// File: rtl/usb_ep_gate_pkg.sv
package usb_ep_gate_pkg;
  localparam int KEEP_W = 9;              // allocation, banks, size, direction, type
  localparam int OPT_W  = 2;              // option bits cleared with the endpoint
  localparam int CFG_W  = KEEP_W + OPT_W;
  localparam int FLAG_W = 4;              // status and mask width
  localparam int TOG_W  = 2;
  localparam int WORD_W = 32;

  typedef struct packed {
    logic [OPT_W-1:0]  opt;
    logic [KEEP_W-1:0] keep;
  } ep_cfg_t;
endpackage

// File: rtl/usb_ep_gate_word.sv
module usb_ep_gate_word
  import usb_ep_gate_pkg::*;
#(
  parameter int NUM_EP    = 10,
  parameter int ADDR_W    = 8,
  parameter int CTRL_ADDR = 'h1C,
  parameter int RST_LSB   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              bus_reset,
  output logic [NUM_EP-1:0] en,
  output logic [NUM_EP-1:0] rstb,
  output logic [WORD_W-1:0] rdata
);
  localparam logic [WORD_W-1:0] EN_MASK  = WORD_W'((64'd1 << NUM_EP) - 64'd1);
  localparam logic [WORD_W-1:0] RST_MASK = EN_MASK << RST_LSB;
  localparam logic [WORD_W-1:0] VALID    = EN_MASK | RST_MASK;

  logic [WORD_W-1:0] word_q;
  logic              hit;

  assign hit = (addr == ADDR_W'(CTRL_ADDR));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (bus_reset) begin
      if (wr && hit) word_q <= wdata & EN_MASK;
      else           word_q <= word_q & ~RST_MASK;
    end else if (wr && hit) begin
      word_q <= wdata & VALID;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          rdata <= '0;
    else if (rd && hit)  rdata <= word_q;
    else                 rdata <= '0;
  end

  assign en   = word_q[NUM_EP-1:0];
  assign rstb = word_q[RST_LSB +: NUM_EP];
endmodule

// File: rtl/usb_ep_gate_slot.sv
module usb_ep_gate_slot
  import usb_ep_gate_pkg::*;
#(
  parameter int CNT_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              rstb,
  input  logic              push_valid,
  output logic              push_ready,
  input  logic              tog_clr,
  input  logic              tog_adv,
  input  logic              cfg_wr,
  input  ep_cfg_t           cfg_wdata,
  input  logic              mask_wr,
  input  logic [FLAG_W-1:0] mask_wdata,
  input  logic              stat_set,
  input  logic [FLAG_W-1:0] stat_bits,
  output logic [CNT_W-1:0]  cnt,
  output logic [TOG_W-1:0]  tog,
  output ep_cfg_t           cfg,
  output logic [FLAG_W-1:0] stat,
  output logic [FLAG_W-1:0] mask
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic live;
  assign live       = en & ~rstb;
  assign push_ready = live && (cnt != CNT_MAX);

  // FIFO byte counter
  always_ff @(posedge clk) begin
    if (!rst_n || !live)              cnt <= '0;
    else if (push_valid && push_ready) cnt <= cnt + 1'b1;
  end

  // data toggle: only the explicit clear resets it
  always_ff @(posedge clk) begin
    if (!rst_n || tog_clr)    tog <= '0;
    else if (tog_adv && live) tog <= tog + 1'b1;
  end

  // kept configuration fields survive disable and endpoint reset
  always_ff @(posedge clk) begin
    if (!rst_n)      cfg.keep <= '0;
    else if (cfg_wr) cfg.keep <= cfg_wdata.keep;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !live) begin
      cfg.opt <= '0;
      stat    <= '0;
      mask    <= '0;
    end else begin
      if (cfg_wr)   cfg.opt <= cfg_wdata.opt;
      if (stat_set) stat    <= stat | stat_bits;
      if (mask_wr)  mask    <= mask_wdata;
    end
  end
endmodule

// File: rtl/usb_ep_gate.sv
module usb_ep_gate
  import usb_ep_gate_pkg::*;
#(
  parameter int NUM_EP    = 10,
  parameter int CNT_W     = 11,
  parameter int ADDR_W    = 8,
  parameter int CTRL_ADDR = 'h1C,
  parameter int RST_LSB   = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_wr,
  input  logic                     reg_rd,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic [WORD_W-1:0]        reg_wdata,
  output logic [WORD_W-1:0]        reg_rdata,
  input  logic                     bus_reset,
  input  logic [NUM_EP-1:0]        tog_clr,
  input  logic [NUM_EP-1:0]        tog_adv,
  input  logic [NUM_EP-1:0]        push_valid,
  output logic [NUM_EP-1:0]        push_ready,
  input  logic [NUM_EP-1:0]        cfg_wr,
  input  logic [CFG_W-1:0]         cfg_wdata,
  input  logic [NUM_EP-1:0]        mask_wr,
  input  logic [FLAG_W-1:0]        mask_wdata,
  input  logic [NUM_EP-1:0]        stat_set,
  input  logic [FLAG_W-1:0]        stat_bits,
  output logic [NUM_EP-1:0]        ep_active,
  output logic [NUM_EP-1:0]        ep_reset,
  output logic [NUM_EP*CNT_W-1:0]  ep_cnt,
  output logic [NUM_EP*TOG_W-1:0]  ep_tog,
  output logic [NUM_EP*CFG_W-1:0]  ep_cfg,
  output logic [NUM_EP*FLAG_W-1:0] ep_stat,
  output logic [NUM_EP*FLAG_W-1:0] ep_mask
);
  logic [NUM_EP-1:0] en;
  logic [NUM_EP-1:0] rstb;
  ep_cfg_t           cfg_in;

  assign cfg_in = ep_cfg_t'(cfg_wdata);

  usb_ep_gate_word #(
    .NUM_EP(NUM_EP), .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .RST_LSB(RST_LSB)
  ) u_word (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .bus_reset(bus_reset), .en(en), .rstb(rstb),
    .rdata(reg_rdata)
  );

  for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
    ep_cfg_t cfg_q;

    usb_ep_gate_slot #(.CNT_W(CNT_W)) u_slot (
      .clk(clk), .rst_n(rst_n), .en(en[i]), .rstb(rstb[i]),
      .push_valid(push_valid[i]), .push_ready(push_ready[i]),
      .tog_clr(tog_clr[i]), .tog_adv(tog_adv[i]),
      .cfg_wr(cfg_wr[i]), .cfg_wdata(cfg_in),
      .mask_wr(mask_wr[i]), .mask_wdata(mask_wdata),
      .stat_set(stat_set[i]), .stat_bits(stat_bits),
      .cnt(ep_cnt[i*CNT_W +: CNT_W]), .tog(ep_tog[i*TOG_W +: TOG_W]),
      .cfg(cfg_q), .stat(ep_stat[i*FLAG_W +: FLAG_W]),
      .mask(ep_mask[i*FLAG_W +: FLAG_W])
    );

    assign ep_cfg[i*CFG_W +: CFG_W] = cfg_q;
  end

  assign ep_active = en;
  assign ep_reset  = rstb;
endmodule

// File: rtl/usb_ep_gate_chk.sv
module usb_ep_gate_chk
  import usb_ep_gate_pkg::*;
#(
  parameter int NUM_EP  = 10,
  parameter int CNT_W   = 11,
  parameter int RST_LSB = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     reg_rd,
  input logic [WORD_W-1:0]        reg_rdata,
  input logic                     bus_reset,
  input logic [NUM_EP-1:0]        tog_clr,
  input logic [NUM_EP-1:0]        tog_adv,
  input logic [NUM_EP-1:0]        ep_active,
  input logic [NUM_EP-1:0]        ep_reset,
  input logic [NUM_EP*CNT_W-1:0]  ep_cnt,
  input logic [NUM_EP*TOG_W-1:0]  ep_tog,
  input logic [NUM_EP*FLAG_W-1:0] ep_stat,
  input logic [NUM_EP*FLAG_W-1:0] ep_mask
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  AST_BUS_RESET_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> (ep_reset == '0)); // R8

  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> (reg_rdata == '0)); // R3

  AST_SPARE_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[RST_LSB-1:NUM_EP] == '0) && (reg_rdata[WORD_W-1:RST_LSB+NUM_EP] == '0)); // R1

  for (genvar i = 0; i < NUM_EP; i++) begin : g_chk
    AST_DISABLED_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !ep_active[i] |=> (ep_cnt[i*CNT_W +: CNT_W] == '0) &&
                        (ep_stat[i*FLAG_W +: FLAG_W] == '0) &&
                        (ep_mask[i*FLAG_W +: FLAG_W] == '0)); // R5

    AST_RESET_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      ep_reset[i] |=> (ep_cnt[i*CNT_W +: CNT_W] == '0)); // R6

    AST_TOGGLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!tog_clr[i] && !tog_adv[i]) |=> $stable(ep_tog[i*TOG_W +: TOG_W])); // R9

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (ep_active[i] && !ep_reset[i] && ep_cnt[i*CNT_W +: CNT_W] == CNT_MAX)
        |=> (ep_cnt[i*CNT_W +: CNT_W] == CNT_MAX)); // R10
  end
endmodule

bind usb_ep_gate usb_ep_gate_chk #(
  .NUM_EP(NUM_EP), .CNT_W(CNT_W), .RST_LSB(RST_LSB)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
  .bus_reset(bus_reset), .tog_clr(tog_clr), .tog_adv(tog_adv),
  .ep_active(ep_active), .ep_reset(ep_reset), .ep_cnt(ep_cnt),
  .ep_tog(ep_tog), .ep_stat(ep_stat), .ep_mask(ep_mask)
);

// File: tb/usb_ep_gate_test.sv
module usb_ep_gate_test;
  localparam int N  = 10;
  localparam int CW = 11;
  localparam logic [CW-1:0] CMAX = '1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 0, reg_rd = 0, bus_reset = 0;
  logic [7:0] reg_addr = 8'h1C;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [N-1:0] tog_clr = '0, tog_adv = '0, push_valid = '0, cfg_wr = '0, mask_wr = '0, stat_set = '0;
  logic [10:0] cfg_wdata = '0;
  logic [3:0] mask_wdata = '0, stat_bits = '0;
  logic [N-1:0] push_ready, ep_active, ep_reset;
  logic [N*CW-1:0] ep_cnt;
  logic [N*2-1:0] ep_tog;
  logic [N*11-1:0] ep_cfg;
  logic [N*4-1:0] ep_stat, ep_mask;

  usb_ep_gate uut (.*);

  always #5 clk = ~clk;

  int checks = 0, failures = 0;

  // reference model state
  logic [N-1:0] m_en = '0, m_rst = '0;
  logic [31:0]  m_rdata = '0;
  logic [CW-1:0] m_cnt [N];
  logic [1:0]   m_tog [N];
  logic [8:0]   m_keep [N];
  logic [1:0]   m_opt [N];
  logic [3:0]   m_stat [N];
  logic [3:0]   m_mask [N];

  function automatic logic [31:0] word_of(logic [N-1:0] e, logic [N-1:0] r);
    return {6'b0, r, 6'b0, e};
  endfunction

  function automatic logic m_live(int i);
    return m_en[i] && !m_rst[i];
  endfunction

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_en = '0; m_rst = '0; m_rdata = '0;
    for (int i = 0; i < N; i++) begin
      m_cnt[i] = '0; m_tog[i] = '0; m_keep[i] = '0; m_opt[i] = '0; m_stat[i] = '0; m_mask[i] = '0;
    end
  endtask

  task automatic model_edge();
    logic hit;
    logic [N-1:0] en_n, rst_n_m;
    hit = (reg_addr == 8'h1C);
    m_rdata = (reg_rd && hit) ? word_of(m_en, m_rst) : 32'h0;
    for (int i = 0; i < N; i++) begin
      logic lv;
      lv = m_live(i);
      if (!lv) m_cnt[i] = '0;
      else if (push_valid[i] && m_cnt[i] != CMAX) m_cnt[i] = m_cnt[i] + 1'b1;
      if (tog_clr[i]) m_tog[i] = '0;
      else if (tog_adv[i] && lv) m_tog[i] = m_tog[i] + 2'd1;
      if (cfg_wr[i]) m_keep[i] = cfg_wdata[8:0];
      if (!lv) begin m_opt[i] = '0; m_stat[i] = '0; m_mask[i] = '0; end
      else begin
        if (cfg_wr[i])   m_opt[i]  = cfg_wdata[10:9];
        if (stat_set[i]) m_stat[i] = m_stat[i] | stat_bits;
        if (mask_wr[i])  m_mask[i] = mask_wdata;
      end
    end
    en_n = m_en; rst_n_m = m_rst;
    if (reg_wr && hit) begin en_n = reg_wdata[N-1:0]; rst_n_m = reg_wdata[16 +: N]; end
    if (bus_reset) rst_n_m = '0;
    m_en = en_n; m_rst = rst_n_m;
  endtask

  task automatic compare_all();
    logic [N*CW-1:0] e_cnt; logic [N*2-1:0] e_tog; logic [N*11-1:0] e_cfg;
    logic [N*4-1:0] e_stat, e_mask; logic [N-1:0] e_rdy;
    for (int i = 0; i < N; i++) begin
      e_cnt[i*CW +: CW] = m_cnt[i];
      e_tog[i*2 +: 2]   = m_tog[i];
      e_cfg[i*11 +: 11] = {m_opt[i], m_keep[i]};
      e_stat[i*4 +: 4]  = m_stat[i];
      e_mask[i*4 +: 4]  = m_mask[i];
      e_rdy[i]          = m_live(i) && m_cnt[i] != CMAX;
    end
    chk("R3 rdata", 128'(reg_rdata), 128'(m_rdata));
    chk("R4 active", 128'(ep_active), 128'(m_en));
    chk("R4 reset", 128'(ep_reset), 128'(m_rst));
    chk("R10 cnt", 128'(ep_cnt), 128'(e_cnt));
    chk("R10 ready", 128'(push_ready), 128'(e_rdy));
    chk("R9 tog", 128'(ep_tog), 128'(e_tog));
    chk("R5 cfg", 128'(ep_cfg), 128'(e_cfg));
    chk("R5 stat", 128'(ep_stat), 128'(e_stat));
    chk("R6 mask", 128'(ep_mask), 128'(e_mask));
  endtask

  task automatic step();
    @(posedge clk);
    if (!rst_n) model_reset(); else model_edge();
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle();
    reg_wr = 0; reg_rd = 0; bus_reset = 0; tog_clr = '0; tog_adv = '0;
    push_valid = '0; cfg_wr = '0; mask_wr = '0; stat_set = '0; reg_addr = 8'h1C;
  endtask

  task automatic write_word(logic [7:0] a, logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    step();
    idle();
  endtask

  task automatic read_word(output logic [31:0] v);
    reg_rd = 1; reg_addr = 8'h1C;
    step();
    v = reg_rdata;
    idle();
  endtask

  logic done = 0;
  initial begin
    #1_500_000ns;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    model_reset();
    @(negedge clk);
    repeat (3) step();
    rst_n = 1;
    step();
    // R2: everything zero out of reset
    read_word(v);
    chk("R2 word", 128'(v), 128'h0);
    chk("R2 cnt", 128'(ep_cnt), 128'h0);

    // R12: write visible in the following cycle; R1: spare bits masked
    write_word(8'h1C, 32'hFC00_FFFF);
    chk("R12 active", 128'(ep_active), 128'(10'h3FF));
    read_word(v);
    chk("R1 word", 128'(v), 128'h0000_03FF);
    write_word(8'h18, 32'h0000_0000);
    chk("R1 other addr write", 128'(ep_active), 128'(10'h3FF));
    reg_rd = 1; reg_addr = 8'h18; step(); idle();
    chk("R1 other addr read", 128'(reg_rdata), 128'h0);

    // R3: read with same-cycle write returns old word
    reg_rd = 1; reg_wr = 1; reg_wdata = 32'h0000_01FF; step(); idle();
    chk("R3 old word", 128'(reg_rdata), 128'h0000_03FF);
    write_word(8'h1C, 32'h0000_03FF);

    // configure, push on endpoint 2, then disable it (R5)
    cfg_wr = '1; cfg_wdata = 11'h7FF; mask_wr = '1; mask_wdata = 4'hA; step(); idle();
    push_valid[2] = 1; repeat (5) step(); idle();
    chk("R10 five pushes", 128'(ep_cnt[2*CW +: CW]), 128'd5);
    write_word(8'h1C, 32'h0000_03FB);
    step();
    chk("R5 cnt cleared", 128'(ep_cnt[2*CW +: CW]), 128'd0);
    chk("R5 keep held", 128'(ep_cfg[2*11 +: 11]), 128'h1FF);
    write_word(8'h1C, 32'h0000_03FF);

    // R11: toggle clear with reset-bit write
    tog_adv[1] = 1; step(); step(); idle();
    chk("R9 advance", 128'(ep_tog[2 +: 2]), 128'd2);
    push_valid[1] = 1; step(); idle();
    tog_clr[1] = 1; reg_wr = 1; reg_wdata = 32'h0002_03FF; step(); idle();
    chk("R11 tog cleared", 128'(ep_tog[2 +: 2]), 128'd0);
    chk("R11 reset set", 128'(ep_reset[1]), 128'd1);
    tog_adv[1] = 1; push_valid[1] = 1; step(); idle();
    chk("R6 cnt cleared", 128'(ep_cnt[CW +: CW]), 128'd0);
    chk("R6 still active", 128'(ep_active[1]), 128'd1);
    chk("R6 tog held", 128'(ep_tog[2 +: 2]), 128'd0);
    chk("R6 keep held", 128'(ep_cfg[11 +: 9]), 128'h1FF);

    // R7: release reset, counting resumes
    write_word(8'h1C, 32'h0000_03FF);
    push_valid[1] = 1; step(); idle();
    chk("R7 resumes", 128'(ep_cnt[CW +: CW]), 128'd1);

    // R8: bus reset wins over write setting reset bits
    write_word(8'h1C, 32'h03FF_03FF);
    bus_reset = 1; reg_wr = 1; reg_wdata = 32'h03FF_03FF; step(); idle();
    chk("R8 resets dropped", 128'(ep_reset), 128'h0);
    chk("R8 enables kept", 128'(ep_active), 128'(10'h3FF));

    // R10: saturation on endpoint 4
    push_valid[4] = 1;
    repeat (2055) step();
    idle();
    chk("R10 saturated", 128'(ep_cnt[4*CW +: CW]), 128'(CMAX));
    chk("R10 ready low when full", 128'(push_ready[4]), 128'd0);

    // constrained random traffic
    for (int k = 0; k < 4000; k++) begin
      reg_wr    = ($urandom % 100) < 4;
      reg_rd    = ($urandom % 100) < 20;
      reg_addr  = (($urandom % 8) == 0) ? 8'h20 : 8'h1C;
      reg_wdata = {$urandom} | 32'h0000_0300;
      reg_wdata[25:16] = 10'($urandom & $urandom & $urandom);
      bus_reset = ($urandom % 100) < 2;
      tog_clr   = N'($urandom & $urandom & $urandom);
      tog_adv   = N'($urandom);
      push_valid = N'($urandom);
      cfg_wr    = N'($urandom & $urandom);
      cfg_wdata = 11'($urandom);
      mask_wr   = N'($urandom & $urandom);
      mask_wdata = 4'($urandom);
      stat_set  = N'($urandom & $urandom);
      stat_bits = 4'($urandom);
      step();
    end
    idle();
    step();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule